// File: doc/BRIEF.md
# Bunch-Crossing Input Alignment Pipeline

This block takes words arriving from a link on the clock recovered from that link. It carries them into the system bunch-crossing clock domain through a dual-clock FIFO. After reset, reading waits until a programmable number of words has built up. From then on one word is read every system cycle, which gives the pipeline a fixed latency. A crossing counter in the system domain restarts on each BC0 marker and wraps at a programmable orbit length. Every word leaving the block carries the counter value of the cycle in which it was read. Several link channels built from this block therefore present words from the same 25 ns bucket with the same crossing number, so they can be lined up for the trigger path.

A selected crossing number can be set at an input. The word read in that crossing is captured and announced with a one-cycle strobe, which lets a test source mark one bucket and recover it on the far side. Faults in keeping the pipeline are reported in the system domain: FIFO overflow, FIFO underflow once reading has begun, and a BC0 that arrives off the expected orbit boundary. Each fault has a sticky flag, and all of them feed a shared saturating counter.

Top module: `bxa_align_pipe`

## Requirements
- R1: Words written with `wr_valid` on `wr_clk` leave on `out_data` in the order they were written, each with `out_valid` high for one `sys_clk` cycle, as long as no overflow occurs.
- R2: After reset, no word is read until the FIFO fill level seen in the system domain reaches `fill_level`. The first `out_valid` therefore follows at least `fill_level` completed writes. From then on a word is read in every system cycle in which the FIFO is not empty.
- R3: The crossing counter is 0 after reset. In the cycle after `bc0` is high it is 0. Otherwise it increments by one each system cycle and wraps from `orbit_len`-1 to 0.
- R4: `out_bx` equals the crossing counter value in the system cycle in which the word on `out_data` was read from the FIFO, and is always below `orbit_len`.
- R5: The first `bc0` after reset never sets an error. Any later `bc0` that arrives while the counter is not at `orbit_len`-1 sets the sticky `err_misalign`.
- R6: A write attempted while the FIFO is full is dropped and sets a sticky overflow flag. That flag reaches `err_ovf` in the system domain after a two-stage synchronizer.
- R7: Once reading has started, a system cycle with an empty FIFO reads nothing (`out_valid` low) and sets the sticky `err_unf`.
- R8: `err_count` starts at 0 after reset. It adds one for each underflow cycle, one for each misaligned `bc0`, and one when `err_overflow` first rises. It saturates at its all-ones value (15 by default).
- R9: In the cycle after a word with `out_bx` equal to `sel_bx` is presented, `sel_hit` is high for one cycle and `sel_data` holds that word until the next such capture.
- R10: During and right after reset, `out_valid`, `sel_hit`, `err_ovf`, `err_unf`, `err_misalign` and `err_count` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Clock recovered from the link (write side) |
| wr_rst | input | 1 | Synchronous active-high reset, write domain |
| wr_valid | input | 1 | Write strobe for `wr_data` |
| wr_data | input | DW | Deserialized link word |
| sys_clk | input | 1 | System bunch-crossing clock (read side) |
| sys_rst | input | 1 | Synchronous active-high reset, system domain |
| bc0 | input | 1 | Orbit start marker, system domain |
| orbit_len | input | BX_W | Number of crossings per orbit |
| fill_level | input | AW+1 | FIFO level that starts reading |
| sel_bx | input | BX_W | Crossing number to capture |
| out_valid | output | 1 | Word on `out_data` is new this cycle |
| out_data | output | DW | Aligned output word |
| out_bx | output | BX_W | Crossing number of `out_data` |
| sel_hit | output | 1 | Selected crossing captured this cycle |
| sel_data | output | DW | Word captured at `sel_bx` |
| err_ovf | output | 1 | Sticky FIFO overflow (synchronized) |
| err_unf | output | 1 | Sticky FIFO underflow |
| err_misalign | output | 1 | Sticky BC0 misalignment |
| err_count | output | ERR_W | Saturating error count |

## Verification
The main path is tried with five configurations. They vary orbit length, start level, selected crossing and BC0 spacing. Equal spacing and orbit length shows that an on-boundary BC0 and the unflagged first BC0 stay silent, while a short spacing must produce one misalignment per later marker. Start levels from 1 up to 8 separate a correct start threshold from one that starts early. Tagging every output word against a crossing model separates correct tags from tags that are off by one cycle or that wrap at the wrong point. Directed runs then starve the FIFO long enough to saturate the counter, and overrun it with a faster write clock so that exactly one overflow count is expected.

// File: rtl/bxa_pkg.sv
package bxa_pkg;
  // sticky fault flags kept in the system domain
  typedef struct packed {
    logic ovf;
    logic unf;
    logic mis;
  } bxa_err_t;
endpackage

// File: rtl/bxa_cdc_fifo.sv
module bxa_cdc_fifo #(
  parameter int DW = 16,
  parameter int AW = 4
) (
  input  logic          wr_clk,
  input  logic          wr_rst,
  input  logic          wr_valid,
  input  logic [DW-1:0] wr_data,
  output logic          ovf_flag,
  input  logic          rd_clk,
  input  logic          rd_rst,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          empty,
  output logic [AW:0]   level
);
  localparam int DEPTH = 1 << AW;
  localparam int PW = AW + 1;

  function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] from_gray(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wbin, wgray, rbin, rgray;
  logic [PW-1:0] rg_s1, rg_s2, wg_s1, wg_s2;
  logic [PW-1:0] wbin_nxt, rbin_nxt;
  logic          full, wr_en;

  assign wbin_nxt = wbin + PW'(1);
  assign rbin_nxt = rbin + PW'(1);
  assign full     = (wgray == {~rg_s2[PW-1:PW-2], rg_s2[PW-3:0]});
  assign wr_en    = wr_valid && !full;
  assign empty    = (rgray == wg_s2);
  assign level    = from_gray(wg_s2) - rbin;

  // write domain
  always_ff @(posedge wr_clk) begin
    if (wr_rst) begin
      wbin     <= '0;
      wgray    <= '0;
      rg_s1    <= '0;
      rg_s2    <= '0;
      ovf_flag <= 1'b0;
    end else begin
      rg_s1 <= rgray;
      rg_s2 <= rg_s1;
      if (wr_en) begin
        wbin  <= wbin_nxt;
        wgray <= to_gray(wbin_nxt);
      end
      if (wr_valid && full) ovf_flag <= 1'b1;
    end
  end

  always_ff @(posedge wr_clk) begin
    if (wr_en) mem[wbin[AW-1:0]] <= wr_data;
  end

  // read domain
  always_ff @(posedge rd_clk) begin
    if (rd_rst) begin
      rbin  <= '0;
      rgray <= '0;
      wg_s1 <= '0;
      wg_s2 <= '0;
    end else begin
      wg_s1 <= wgray;
      wg_s2 <= wg_s1;
      if (rd_en) begin
        rbin  <= rbin_nxt;
        rgray <= to_gray(rbin_nxt);
      end
    end
  end

  always_ff @(posedge rd_clk) begin
    if (rd_en) rd_data <= mem[rbin[AW-1:0]];
  end

  AST_OVF_STICKY: assert property (@(posedge wr_clk) disable iff (wr_rst)
    ovf_flag |=> ovf_flag); // R6
  AST_NO_READ_EMPTY: assert property (@(posedge rd_clk) disable iff (rd_rst)
    rd_en |-> !empty); // R7
  AST_LEVEL_BOUND: assert property (@(posedge rd_clk) disable iff (rd_rst)
    level <= PW'(DEPTH)); // R1
endmodule

// File: rtl/bxa_bx_counter.sv
module bxa_bx_counter #(
  parameter int BX_W = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bc0,
  input  logic [BX_W-1:0] orbit_len,
  output logic [BX_W-1:0] bx,
  output logic            mis_evt,
  output logic            err_mis
);
  logic            locked;
  logic [BX_W-1:0] last_bx;

  assign last_bx = orbit_len - BX_W'(1);
  assign mis_evt = bc0 && locked && (bx != last_bx);

  always_ff @(posedge clk) begin
    if (rst) begin
      bx      <= '0;
      locked  <= 1'b0;
      err_mis <= 1'b0;
    end else begin
      if (bc0) begin
        bx     <= '0;
        locked <= 1'b1;
      end else if (bx >= last_bx) begin
        bx <= '0;
      end else begin
        bx <= bx + BX_W'(1);
      end
      if (mis_evt) err_mis <= 1'b1;
    end
  end

  AST_BC0_RESTART: assert property (@(posedge clk) disable iff (rst)
    bc0 |=> (bx == '0)); // R3
  AST_BX_WRAP: assert property (@(posedge clk) disable iff (rst)
    (!bc0 && bx == last_bx) |=> (bx == '0)); // R3
  AST_MIS_STICKY: assert property (@(posedge clk) disable iff (rst)
    err_mis |=> err_mis); // R5
endmodule

// File: rtl/bxa_align_pipe.sv
module bxa_align_pipe #(
  parameter int DW    = 16,
  parameter int AW    = 4,
  parameter int BX_W  = 12,
  parameter int ERR_W = 4
) (
  input  logic             wr_clk,
  input  logic             wr_rst,
  input  logic             wr_valid,
  input  logic [DW-1:0]    wr_data,
  input  logic             sys_clk,
  input  logic             sys_rst,
  input  logic             bc0,
  input  logic [BX_W-1:0]  orbit_len,
  input  logic [AW:0]      fill_level,
  input  logic [BX_W-1:0]  sel_bx,
  output logic             out_valid,
  output logic [DW-1:0]    out_data,
  output logic [BX_W-1:0]  out_bx,
  output logic             sel_hit,
  output logic [DW-1:0]    sel_data,
  output logic             err_ovf,
  output logic             err_unf,
  output logic             err_misalign,
  output logic [ERR_W-1:0] err_count
);
  import bxa_pkg::*;

  localparam int CW = ERR_W + 1;
  localparam logic [ERR_W-1:0] ERR_MAX = '1;

  logic            fifo_ovf, fifo_empty, rd_en, started;
  logic [AW:0]     fifo_level;
  logic [BX_W-1:0] bx;
  logic            mis_evt, unf_evt, ovf_rise;
  logic            ovf_s1, ovf_s2, ovf_s3;
  logic [CW-1:0]   err_sum;
  bxa_err_t        flags;

  bxa_cdc_fifo #(.DW(DW), .AW(AW)) u_fifo (
    .wr_clk   (wr_clk),
    .wr_rst   (wr_rst),
    .wr_valid (wr_valid),
    .wr_data  (wr_data),
    .ovf_flag (fifo_ovf),
    .rd_clk   (sys_clk),
    .rd_rst   (sys_rst),
    .rd_en    (rd_en),
    .rd_data  (out_data),
    .empty    (fifo_empty),
    .level    (fifo_level)
  );

  bxa_bx_counter #(.BX_W(BX_W)) u_bx (
    .clk       (sys_clk),
    .rst       (sys_rst),
    .bc0       (bc0),
    .orbit_len (orbit_len),
    .bx        (bx),
    .mis_evt   (mis_evt),
    .err_mis   (flags.mis)
  );

  assign rd_en    = started && !fifo_empty;
  assign unf_evt  = started && fifo_empty;
  assign ovf_rise = ovf_s2 && !ovf_s3;
  assign err_sum  = {1'b0, err_count} + CW'(ovf_rise) + CW'(unf_evt) + CW'(mis_evt);

  assign flags.ovf    = ovf_s2;
  assign err_ovf      = flags.ovf;
  assign err_unf      = flags.unf;
  assign err_misalign = flags.mis;

  always_ff @(posedge sys_clk) begin
    if (sys_rst) begin
      started   <= 1'b0;
      out_valid <= 1'b0;
      out_bx    <= '0;
      sel_hit   <= 1'b0;
      sel_data  <= '0;
      ovf_s1    <= 1'b0;
      ovf_s2    <= 1'b0;
      ovf_s3    <= 1'b0;
      flags.unf <= 1'b0;
      err_count <= '0;
    end else begin
      if (fifo_level >= fill_level) started <= 1'b1;
      out_valid <= rd_en;
      if (rd_en) out_bx <= bx;
      sel_hit <= out_valid && (out_bx == sel_bx);
      if (out_valid && (out_bx == sel_bx)) sel_data <= out_data;
      ovf_s1 <= fifo_ovf;
      ovf_s2 <= ovf_s1;
      ovf_s3 <= ovf_s2;
      if (unf_evt) flags.unf <= 1'b1;
      err_count <= err_sum[ERR_W] ? ERR_MAX : err_sum[ERR_W-1:0];
    end
  end

  AST_UNF_STICKY: assert property (@(posedge sys_clk) disable iff (sys_rst)
    err_unf |=> err_unf); // R7
  AST_SEL_STROBE: assert property (@(posedge sys_clk) disable iff (sys_rst)
    sel_hit |-> $past(out_valid && (out_bx == sel_bx))); // R9
  AST_ERR_SATURATE: assert property (@(posedge sys_clk) disable iff (sys_rst)
    (err_count == ERR_MAX) |=> (err_count == ERR_MAX)); // R8
  AST_BX_IN_ORBIT: assert property (@(posedge sys_clk) disable iff (sys_rst)
    out_valid |-> (out_bx < orbit_len)); // R4
endmodule

// File: tb/test_bxa_align_pipe.sv
module test_bxa_align_pipe;
  localparam int SYS_PERIOD = 10;
  localparam int DW = 16, AW = 4, BX_W = 12, ERR_W = 4;
  localparam int NROWS = 5;
  // columns: orbit length, start level, selected crossing, BC0 spacing, misalign expected
  localparam int TBL [NROWS][5] = '{
    '{8, 4, 3, 8, 0},
    '{12, 2, 0, 12, 0},
    '{5, 8, 4, 5, 0},
    '{8, 4, 2, 6, 1},
    '{16, 1, 15, 16, 0}
  };

  logic wr_clk, wr_rst, wr_valid, sys_clk, sys_rst, bc0;
  logic [DW-1:0] wr_data, out_data, sel_data;
  logic [BX_W-1:0] orbit_len, sel_bx, out_bx;
  logic [AW:0] fill_level;
  logic out_valid, sel_hit, err_ovf, err_unf, err_misalign;
  logic [ERR_W-1:0] err_count;

  bxa_align_pipe #(.DW(DW), .AW(AW), .BX_W(BX_W), .ERR_W(ERR_W)) i_bxa_align_pipe (
    .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_valid(wr_valid), .wr_data(wr_data),
    .sys_clk(sys_clk), .sys_rst(sys_rst), .bc0(bc0), .orbit_len(orbit_len),
    .fill_level(fill_level), .sel_bx(sel_bx), .out_valid(out_valid),
    .out_data(out_data), .out_bx(out_bx), .sel_hit(sel_hit), .sel_data(sel_data),
    .err_ovf(err_ovf), .err_unf(err_unf), .err_misalign(err_misalign),
    .err_count(err_count)
  );

  int wr_half = 5;
  int checks = 0, fails = 0, nwritten = 0;
  int m = 0, m_prev = 0, exp_cnt = 0;
  bit locked = 0;

  initial begin
    wr_clk = 0;
    forever #(wr_half) wr_clk = ~wr_clk;
  end
  initial begin
    sys_clk = 0;
    #2;
    forever #(SYS_PERIOD / 2) sys_clk = ~sys_clk;
  end

  // crossing model built from R3/R5
  always @(posedge sys_clk) begin
    m_prev = m;
    if (sys_rst) begin
      m = 0; locked = 0; exp_cnt = 0;
    end else begin
      if (bc0 && locked && m != int'(orbit_len) - 1) exp_cnt++;
      if (bc0) begin
        locked = 1; m = 0;
      end else m = (m >= int'(orbit_len) - 1) ? 0 : m + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge sys_clk);
    sys_rst = 1; wr_rst = 1; bc0 = 0; wr_valid = 0;
    repeat (6) @(negedge sys_clk);
    sys_rst = 0; wr_rst = 0;
    nwritten = 0;
  endtask

  task automatic write_words(input int n, input int base);
    for (int i = 0; i < n; i++) begin
      @(negedge wr_clk);
      wr_valid = 1; wr_data = DW'(base + i);
      @(posedge wr_clk);
      #1 nwritten++;
    end
    @(negedge wr_clk);
    wr_valid = 0;
  endtask

  task automatic run_row(input int r);
    int base, per, data_bad, bx_bad, sel_bad, sel_seen, lat_written, exp_data;
    bit first_seen;
    int by_bx [int];
    base = (r + 1) * 256; per = TBL[r][3];
    data_bad = 0; bx_bad = 0; sel_bad = 0; sel_seen = 0; lat_written = -1;
    exp_data = base; first_seen = 0;
    orbit_len = BX_W'(TBL[r][0]); fill_level = (AW+1)'(TBL[r][1]); sel_bx = BX_W'(TBL[r][2]);
    do_reset();
    fork
      write_words(60, base);
      begin
        for (int k = 0; k < 40; k++) begin
          @(negedge sys_clk);
          if (sel_hit) begin
            sel_seen++;
            if (!by_bx.exists(int'(sel_bx)) || int'(sel_data) != by_bx[int'(sel_bx)]) sel_bad++;
          end
          if (out_valid) begin
            if (!first_seen) begin first_seen = 1; lat_written = nwritten; end
            if (int'(out_data) != exp_data) data_bad++;
            exp_data = int'(out_data) + 1;
            if (int'(out_bx) != m_prev) bx_bad++;
            by_bx[int'(out_bx)] = int'(out_data);
          end
          bc0 = (k >= 3) && ((k - 3) % per == 0);
        end
        chk(first_seen && data_bad == 0, "R1 ordered words", data_bad, 0);
        chk(lat_written >= TBL[r][1], "R2 start level", lat_written, TBL[r][1]);
        chk(bx_bad == 0, "R4 crossing tag (R3 counter)", bx_bad, 0);
        chk(sel_seen > 0 && sel_bad == 0, "R9 selected bucket", sel_bad, 0);
        chk(int'(err_misalign) == TBL[r][4], "R5 misalign flag", int'(err_misalign), TBL[r][4]);
        chk(int'(err_count) == (exp_cnt > 15 ? 15 : exp_cnt), "R8 error count", int'(err_count), exp_cnt);
        chk(err_unf == 0 && err_ovf == 0, "R7 no fault while streaming", int'(err_unf), 0);
        bc0 = 0;
      end
    join
  endtask

  initial begin
    #1_000_000;
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    wr_valid = 0; wr_data = '0; bc0 = 0; sys_rst = 1; wr_rst = 1;
    orbit_len = 12'd8; fill_level = 5'd4; sel_bx = '0;
    repeat (3) @(negedge sys_clk);
    // R10 during reset
    chk(!out_valid && !sel_hit && !err_ovf && !err_unf && !err_misalign && err_count == 0,
        "R10 reset state", int'(err_count), 0);
    do_reset();
    @(negedge sys_clk);
    chk(!out_valid && !err_ovf && !err_unf && !err_misalign && err_count == 0,
        "R10 after reset", int'(out_valid), 0);

    for (int r = 0; r < NROWS; r++) run_row(r);

    // R7/R8: starve the FIFO until the counter saturates
    orbit_len = 12'd8; fill_level = 5'd2; sel_bx = 12'd100;
    do_reset();
    write_words(4, 16'h0400);
    repeat (40) @(negedge sys_clk);
    chk(err_unf == 1, "R7 underflow flag", int'(err_unf), 1);
    chk(out_valid == 0, "R7 no word on empty", int'(out_valid), 0);
    chk(int'(err_count) == 15, "R8 saturation", int'(err_count), 15);
    chk(err_ovf == 0 && err_misalign == 0, "R8 only underflow counted", int'(err_ovf), 0);

    // R6/R8: overrun with a faster write clock
    fill_level = 5'd16;
    do_reset();
    wr_half = 2;
    write_words(100, 16'h0800);
    @(negedge sys_clk);
    chk(err_ovf == 1, "R6 overflow flag", int'(err_ovf), 1);
    chk(int'(err_count) == 1, "R8 overflow counted once", int'(err_count), 1);
    chk(err_unf == 0, "R6 no underflow while overrun", int'(err_unf), 0);
    wr_half = 5;

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule